// File: doc/BRIEF.md
# Branch folding decode unit

This unit sits after instruction decode and in front of a small store of decoded entries. Each cycle it may take one decoded instruction. The instruction comes with its address, its length, a kind code, an operation code and, for branches, a target and a static prediction bit.

The unit absorbs a branch into the entry of the instruction just before it. That entry then carries two successor addresses: the next address, which is the predicted path, and for conditional branches an alternate address, which is the path not taken. A folded branch never needs an execute slot of its own.

To see whether a branch follows, a non-branch instruction is held for exactly one cycle. Entries go into a circular array in the order they are produced. A consumer reads them out one at a time with a read strobe, and the data comes back one cycle later from a registered read port that maps onto block RAM. While the array is full, the unit raises a stall toward the decoder.

Top module: `bf_fold_top`

## Requirements
- R1: After synchronous reset, `stall`, `ent_avail` and `rd_vld` are all low.
- R2: A non-branch instruction (kind 2'b00 plain, 2'b01 compare) accepted in the cycle right before a branch (kind 2'b10 unconditional, 2'b11 conditional) yields exactly one entry. That entry has the address and operation of the non-branch instruction, `ent_folded`=1, and successors taken from the branch. The branch makes no entry of its own.
- R3: The entry for an unconditional branch, folded or alone, has next = branch target, `ent_alt_vld`=0, alt = 0 and `ent_pred`=0.
- R4: The entry for a conditional branch with prediction 1 has next = target and alt = branch address + branch length. With prediction 0 it has next = branch address + branch length and alt = target. In both cases `ent_alt_vld`=1 and `ent_pred` equals the prediction bit.
- R5: A non-branch instruction followed directly by another non-branch instruction makes its own entry with next = its address + its length (modulo 2^AW), alt = 0, `ent_alt_vld`=0 and `ent_folded`=0.
- R6: A branch that does not directly follow a held non-branch instruction makes its own entry, with the branch address and operation and `ent_folded`=0. This covers any branch right after another branch, and so a conditional branch right after a conditional branch.
- R7: A cycle with no accepted input after a non-branch instruction releases that instruction as an unfolded entry, as in R5. A branch after such a gap is not folded.
- R8: `ent_flag_wr` is 1 exactly when the head instruction of the entry is a compare.
- R9: `stall` is high exactly when the store holds DEPTH entries. While it is high, the input is ignored and a held instruction stays held. No entry is lost or duplicated.
- R10: A high `rd_en` while `ent_avail` is high presents the oldest entry on the `ent_*` outputs one cycle later, with `rd_vld`=1. Entries come out in the order they were made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_kind | input | 2 | 00 plain, 01 compare, 10 unconditional branch, 11 conditional branch |
| in_op | input | OPW | Operation code |
| in_addr | input | AW | Instruction address |
| in_len | input | LW | Instruction length |
| in_target | input | AW | Branch target |
| in_pred | input | 1 | Static prediction, 1 = taken |
| stall | output | 1 | Store full, input not accepted |
| rd_en | input | 1 | Read strobe for the oldest entry |
| ent_avail | output | 1 | Store holds at least one entry |
| rd_vld | output | 1 | Read data valid this cycle |
| ent_op | output | OPW | Entry operation |
| ent_addr | output | AW | Entry head address |
| ent_next | output | AW | Next (predicted) address |
| ent_alt | output | AW | Alternate address |
| ent_alt_vld | output | 1 | Alternate address valid |
| ent_pred | output | 1 | Prediction bit of folded conditional |
| ent_folded | output | 1 | Entry absorbed a branch |
| ent_flag_wr | output | 1 | Head instruction writes the condition flag |

## Verification
The hardest case to reach is a full store while a non-branch instruction is still held. The branch that arrives during the stall must be refused, and the held instruction must still fold with the first branch accepted after the stall clears. A directed phase disables reads, streams instructions until the stall rises, keeps offering branches during the stall and then drains the store. A long random phase with a low read rate then keeps the store near full while kinds, gaps and predictions vary.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [1:0] {
    KIND_OP  = 2'b00,
    KIND_CMP = 2'b01,
    KIND_JMP = 2'b10,
    KIND_BR  = 2'b11
  } bf_kind_e;

  function automatic logic kind_is_branch(input logic [1:0] k);
    return k[1];
  endfunction
endpackage

// File: rtl/bf_seq_adder.sv
module bf_seq_adder #(
  parameter int AW = 16,
  parameter int LW = 3
) (
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] seq
);
  localparam int PADW = AW - LW;
  assign seq = base + {{PADW{1'b0}}, len};
endmodule

// File: rtl/bf_succ_sel.sv
module bf_succ_sel #(
  parameter int AW = 16,
  parameter int LW = 3
) (
  input  logic [1:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] len,
  input  logic [AW-1:0] target,
  input  logic          pred,
  output logic [AW-1:0] nxt,
  output logic [AW-1:0] alt,
  output logic          alt_vld,
  output logic          pred_out
);
  import bf_pkg::*;
  logic [AW-1:0] fall;
  logic          cond;

  bf_seq_adder #(.AW(AW), .LW(LW)) u_fall (.base(addr), .len(len), .seq(fall));

  assign cond = (kind == KIND_BR);

  always_comb begin
    if (cond) begin
      nxt      = pred ? target : fall;
      alt      = pred ? fall : target;
      alt_vld  = 1'b1;
      pred_out = pred;
    end else begin
      nxt      = target;
      alt      = '0;
      alt_vld  = 1'b0;
      pred_out = 1'b0;
    end
  end
endmodule

// File: rtl/bf_fold_core.sv
module bf_fold_core #(
  parameter int AW  = 16,
  parameter int OPW = 8,
  parameter int LW  = 3,
  localparam int EW = OPW + 3*AW + 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [1:0]     in_kind,
  input  logic [OPW-1:0] in_op,
  input  logic [AW-1:0]  in_addr,
  input  logic [LW-1:0]  in_len,
  input  logic [AW-1:0]  in_target,
  input  logic           in_pred,
  input  logic           stall,
  output logic           wr_en,
  output logic [EW-1:0]  wr_ent
);
  import bf_pkg::*;

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [AW-1:0]  addr;
    logic [AW-1:0]  nxt;
    logic [AW-1:0]  alt;
    logic           alt_vld;
    logic           pred;
    logic           folded;
    logic           flag_wr;
  } ent_t;

  logic           hold_vld;
  logic [OPW-1:0] hold_op;
  logic [AW-1:0]  hold_addr;
  logic [LW-1:0]  hold_len;
  logic           hold_cmp;

  logic           acc, in_br;
  logic [AW-1:0]  br_nxt, br_alt, hold_nxt;
  logic           br_alt_vld, br_pred;
  ent_t           ent;

  assign acc   = in_valid && !stall;
  assign in_br = kind_is_branch(in_kind);

  bf_succ_sel #(.AW(AW), .LW(LW)) u_br_sel (
    .kind(in_kind), .addr(in_addr), .len(in_len), .target(in_target),
    .pred(in_pred), .nxt(br_nxt), .alt(br_alt), .alt_vld(br_alt_vld),
    .pred_out(br_pred)
  );

  bf_seq_adder #(.AW(AW), .LW(LW)) u_hold_seq (
    .base(hold_addr), .len(hold_len), .seq(hold_nxt)
  );

  always_comb begin
    wr_en = 1'b0;
    ent   = '0;
    if (!stall) begin
      if (hold_vld) begin
        wr_en       = 1'b1;
        ent.op      = hold_op;
        ent.addr    = hold_addr;
        ent.flag_wr = hold_cmp;
        if (acc && in_br) begin
          ent.nxt     = br_nxt;
          ent.alt     = br_alt;
          ent.alt_vld = br_alt_vld;
          ent.pred    = br_pred;
          ent.folded  = 1'b1;
        end else begin
          ent.nxt = hold_nxt;
        end
      end else if (acc && in_br) begin
        wr_en       = 1'b1;
        ent.op      = in_op;
        ent.addr    = in_addr;
        ent.nxt     = br_nxt;
        ent.alt     = br_alt;
        ent.alt_vld = br_alt_vld;
        ent.pred    = br_pred;
      end
    end
  end

  assign wr_ent = ent;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld  <= 1'b0;
      hold_op   <= '0;
      hold_addr <= '0;
      hold_len  <= '0;
      hold_cmp  <= 1'b0;
    end else if (!stall) begin
      hold_vld <= acc && !in_br;
      if (acc && !in_br) begin
        hold_op   <= in_op;
        hold_addr <= in_addr;
        hold_len  <= in_len;
        hold_cmp  <= (in_kind == KIND_CMP);
      end
    end
  end

  AST_FOLD_ONE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (hold_vld && !stall && in_valid && in_br) |-> (wr_en && ent.folded && ent.addr == hold_addr)); // R2
  AST_STALL_KEEPS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stall && hold_vld) |=> (hold_vld && $stable(hold_addr))); // R9
  AST_GAP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (hold_vld && !stall && !in_valid) |=> !hold_vld); // R7
  AST_ALT_ONLY_COND: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ent.alt_vld) |-> (ent.alt == '0 && !ent.pred)); // R3
endmodule

// File: rtl/bf_entry_buf.sv
module bf_entry_buf #(
  parameter int EW    = 60,
  parameter int DEPTH = 8,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [EW-1:0] wr_ent,
  input  logic          rd_en,
  output logic [EW-1:0] rd_data,
  output logic          rd_vld,
  output logic          avail,
  output logic          full
);
  logic [EW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0]   count, count_nx;
  logic            rd_do;

  assign rd_do = rd_en && (count != '0);

  always_comb begin
    count_nx = count;
    if (wr_en && !rd_do)      count_nx = count + 1'b1;
    else if (!wr_en && rd_do) count_nx = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (rd_do) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == PTRW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_do) rd_ptr <= (rd_ptr == PTRW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count  <= count_nx;
      full   <= (count_nx == CW'(DEPTH));
      rd_vld <= rd_do;
    end
  end

  assign avail = (count != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (count < CW'(DEPTH))); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + 1'b1) || (count == $past(count) - 1'b1)); // R9
  AST_READ_HAD_DATA: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> ($past(count) != '0)); // R10
  AST_FULL_MATCHES: assert property (@(posedge clk) disable iff (rst)
    full |-> (count == CW'(DEPTH))); // R9
endmodule

// File: rtl/bf_fold_top.sv
module bf_fold_top #(
  parameter int AW    = 16,
  parameter int OPW   = 8,
  parameter int LW    = 3,
  parameter int DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [1:0]     in_kind,
  input  logic [OPW-1:0] in_op,
  input  logic [AW-1:0]  in_addr,
  input  logic [LW-1:0]  in_len,
  input  logic [AW-1:0]  in_target,
  input  logic           in_pred,
  output logic           stall,
  input  logic           rd_en,
  output logic           ent_avail,
  output logic           rd_vld,
  output logic [OPW-1:0] ent_op,
  output logic [AW-1:0]  ent_addr,
  output logic [AW-1:0]  ent_next,
  output logic [AW-1:0]  ent_alt,
  output logic           ent_alt_vld,
  output logic           ent_pred,
  output logic           ent_folded,
  output logic           ent_flag_wr
);
  localparam int EW = OPW + 3*AW + 4;

  logic          wr_en;
  logic [EW-1:0] wr_ent, rd_data;

  bf_fold_core #(.AW(AW), .OPW(OPW), .LW(LW)) u_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_op(in_op), .in_addr(in_addr), .in_len(in_len),
    .in_target(in_target), .in_pred(in_pred), .stall(stall),
    .wr_en(wr_en), .wr_ent(wr_ent)
  );

  bf_entry_buf #(.EW(EW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ent(wr_ent),
    .rd_en(rd_en), .rd_data(rd_data), .rd_vld(rd_vld),
    .avail(ent_avail), .full(stall)
  );

  assign {ent_op, ent_addr, ent_next, ent_alt, ent_alt_vld,
          ent_pred, ent_folded, ent_flag_wr} = rd_data;

  AST_RD_NEEDS_AVAIL: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(ent_avail)); // R10
endmodule

// File: tb/bf_fold_top_test.sv
`timescale 1ns/1ps
module bf_fold_top_test;
  localparam int AW = 16, OPW = 8, LW = 3, DEPTH = 8;
  localparam int EW = OPW + 3*AW + 4;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_pred = 0, rd_en = 0;
  logic [1:0] in_kind = 0;
  logic [OPW-1:0] in_op = 0;
  logic [AW-1:0] in_addr = 0, in_target = 0;
  logic [LW-1:0] in_len = 0;
  logic stall, ent_avail, rd_vld, ent_alt_vld, ent_pred, ent_folded, ent_flag_wr;
  logic [OPW-1:0] ent_op;
  logic [AW-1:0] ent_addr, ent_next, ent_alt;

  always #4 clk = ~clk;

  bf_fold_top #(.AW(AW), .OPW(OPW), .LW(LW), .DEPTH(DEPTH)) uut (.*);

  typedef struct { logic [EW-1:0] e; string tag; } exp_t;
  exp_t expq[$];
  int checks = 0, errors = 0, m_cnt = 0;
  bit done = 0;
  logic m_hv = 0, m_hcmp = 0;
  logic [OPW-1:0] m_hop;
  logic [AW-1:0] m_haddr, cur_addr = 16'h0100;
  logic [LW-1:0] m_hlen;
  logic pend = 0;

  task automatic chk(input bit ok, input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] seqa(input logic [AW-1:0] a, input logic [LW-1:0] l);
    return a + AW'(l);
  endfunction

  task automatic model(input logic [1:0] k, input logic [OPW-1:0] op, input logic [AW-1:0] a,
                       input logic [LW-1:0] l, input logic [AW-1:0] t, input logic p, input logic v);
    logic br;
    logic [AW-1:0] nx, al, fa;
    logic av, pr;
    exp_t x;
    br = v && k[1];
    fa = seqa(a, l);
    av = (k == 2'b11);
    pr = av && p;
    nx = (k == 2'b10) ? t : (p ? t : fa);
    al = av ? (p ? fa : t) : '0;
    if (m_hv) begin
      if (br) begin
        x.e = {m_hop, m_haddr, nx, al, av, pr, 1'b1, m_hcmp};
        x.tag = av ? "R2 R4" : "R2 R3";
      end else begin
        x.e = {m_hop, m_haddr, seqa(m_haddr, m_hlen), AW'(0), 1'b0, 1'b0, 1'b0, m_hcmp};
        x.tag = v ? "R5" : "R7";
      end
      if (m_hcmp) x.tag = {x.tag, " R8"};
      expq.push_back(x);
      m_cnt++;
    end else if (br) begin
      x.e = {op, a, nx, al, av, pr, 1'b0, 1'b0};
      x.tag = av ? "R6 R4" : "R6 R3";
      expq.push_back(x);
      m_cnt++;
    end
    m_hv = v && !k[1];
    if (m_hv) begin
      m_hop = op; m_haddr = a; m_hlen = l; m_hcmp = (k == 2'b01);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] k, input logic [LW-1:0] l,
                      input logic [AW-1:0] t, input logic p, input logic pop);
    logic [OPW-1:0] op;
    logic popped, st;
    op = OPW'($urandom);
    st = stall;
    chk(st == (m_cnt == DEPTH), "R9 stall", EW'(st), EW'(m_cnt == DEPTH));
    chk(ent_avail == (m_cnt != 0), "R10 avail", EW'(ent_avail), EW'(m_cnt != 0));
    in_valid = v; in_kind = k; in_op = op; in_addr = cur_addr; in_len = l;
    in_target = t; in_pred = p; rd_en = pop;
    popped = pop && (m_cnt > 0);
    if (popped) m_cnt--;
    if (!st) begin
      model(k, op, cur_addr, l, t, p, v);
      if (v) cur_addr = seqa(cur_addr, l);
    end else if (m_hv) begin
      chk(1'b1, "R9 held during stall", '0, '0);
    end
    @(negedge clk);
    chk(rd_vld == popped, "R10 rd_vld", EW'(rd_vld), EW'(popped));
    if (popped && rd_vld) begin
      exp_t f;
      logic [EW-1:0] act;
      f = expq.pop_front();
      act = {ent_op, ent_addr, ent_next, ent_alt, ent_alt_vld, ent_pred, ent_folded, ent_flag_wr};
      chk(act == f.e, {f.tag, " R10"}, act, f.e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!stall && !ent_avail && !rd_vld, "R1 reset", EW'({stall, ent_avail, rd_vld}), '0);
    // directed: fold with jump, conditional both predictions, compare head
    step(1, 2'b00, 3'd2, 16'h0400, 0, 1);
    step(1, 2'b10, 3'd1, 16'h0400, 0, 1);
    step(1, 2'b00, 3'd4, 16'h0500, 0, 1);
    step(1, 2'b11, 3'd2, 16'h0600, 1, 1);
    step(1, 2'b01, 3'd3, 16'h0700, 0, 1);
    step(1, 2'b11, 3'd2, 16'h0800, 0, 1);
    // branch after branch, conditional after conditional
    step(1, 2'b11, 3'd2, 16'h0900, 1, 1);
    step(1, 2'b11, 3'd2, 16'h0A00, 0, 1);
    step(1, 2'b10, 3'd1, 16'h0B00, 0, 1);
    // gap after non-branch, then branch after gap
    step(1, 2'b00, 3'd2, 16'h0, 0, 1);
    step(0, 2'b00, 3'd1, 16'h0, 0, 1);
    step(1, 2'b10, 3'd1, 16'h0C00, 0, 1);
    // run of plain ops, address wrap
    cur_addr = 16'hFFFC;
    step(1, 2'b00, 3'd3, 16'h0, 0, 1);
    step(1, 2'b01, 3'd3, 16'h0, 0, 1);
    step(1, 2'b00, 3'd7, 16'h0, 0, 1);
    // fill the store without reads, keep offering branches during stall
    for (int i = 0; i < 12; i++) step(1, 2'b00, 3'd1, 16'h0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 2'b11, 3'd2, 16'h0D00, 1, 0);
    for (int i = 0; i < 40; i++) step(1, 2'b11, 3'd2, 16'h0E00, 0, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[3:0] != 0, r[5:4], LW'(r[8:6] | 3'd1), AW'($urandom), r[9], (r[13:10] < (i < 2000 ? 4'd6 : 4'd9)));
    end
    for (int i = 0; i < 40 && (m_cnt != 0 || m_hv); i++) step(0, 2'b00, 3'd1, 16'h0, 0, 1);
    chk(m_cnt == 0 && expq.size() == 0, "R9 drain complete", EW'(m_cnt), '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule